// File: doc/BRIEF.md
# LIN Header Receiver

This block acquires the header of a LIN frame on its own, with no software involvement, whenever the controller is enabled and its three-bit command is the header-receive value (000). It watches a receive line that is sampled once per clock. It first waits for a break, which is a long dominant low. It then times the sync byte to find the real bit period of the sending node. Using that period, it samples the protected identifier byte and checks the two parity bits of that byte.

When a header arrives whole with correct parity, the block raises a header-received flag and gives a one-cycle pulse that starts the frame timeout counter. In legacy (1.3) mode it also decodes the response length from the identifier. If the sync timing is too far from nominal, the block flags a sync error. If the parity does not match, it flags a parity error. Any new break clears the flags. If the controller leaves header-receive mode or is disabled, the acquisition falls back to waiting for a break.

Top module: `lin_hdr_rx`

## Requirements
- R1: After reset, the outputs are as follows. `hdr_ok_o`, `par_err_o`, `sync_err_o` and `tmo_start_o` are 0. `pid_o` and `dlen_o` are 0. `bit_per_o` equals NOM_BIT (16).
- R2: A break is recognised only when the line goes high after staying low for at least BRK_BITS*NOM_BIT clocks (176 by default). A low that is one clock shorter starts no acquisition and leaves every output unchanged.
- R3: After a break, the clocks between the first and the fifth falling edge of the sync byte (0x55, sent LSB first) are counted. That count, divided by 8 and rounded down, is loaded into `bit_per_o`.
- R4: If the sync count falls outside [floor(8*NOM*(100-TOL)/100), floor(8*NOM*(100+TOL)/100)] (110 to 145 by default), `sync_err_o` is set. In that case `bit_per_o` keeps its value, no identifier is taken and `hdr_ok_o` stays 0.
- R5: The identifier byte is sampled near mid-bit using the newly measured period, LSB first. All 8 bits appear on `pid_o`, with bit 6 = P0 and bit 7 = P1.
- R6: P0 must equal id0^id1^id2^id4, and P1 must equal the inverse of id1^id3^id4^id5. On a mismatch, `par_err_o` is set and `hdr_ok_o` stays 0. `pid_o` still shows the received byte.
- R7: With `lin13_i` high, a good header loads `dlen_o` from identifier bits 5:4 as follows: 00 gives 2, 01 gives 2, 10 gives 4, 11 gives 8. With `lin13_i` low, `dlen_o` holds its value.
- R8: A header with good parity sets `hdr_ok_o`. In the same cycle, `tmo_start_o` pulses high for exactly one cycle.
- R9: Every recognised break clears `hdr_ok_o`, `par_err_o` and `sync_err_o`.
- R10: While `en_i` is 0 or `cmd_i` is not 000, the acquisition returns to waiting for a break. A header that was in progress is abandoned: it does not change `pid_o` or `bit_per_o` and does not pulse `tmo_start_o`, even if its remaining bits arrive later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the line is sampled on each rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Controller enable |
| cmd_i | input | 3 | Command; 000 selects header receive |
| lin13_i | input | 1 | Legacy 1.3 mode: decode the length from the identifier |
| rx_i | input | 1 | Receive line sample, idle high |
| pid_o | output | 8 | Last received protected identifier |
| dlen_o | output | 4 | Decoded response length in bytes |
| bit_per_o | output | $clog2(16*NOM_BIT) | Measured bit period in clocks |
| hdr_ok_o | output | 1 | Header received with good parity |
| par_err_o | output | 1 | Identifier parity error |
| sync_err_o | output | 1 | Sync timing out of tolerance |
| tmo_start_o | output | 1 | One-cycle pulse that starts the frame timeout |

## Verification
The hardest situation to reach is a header that is cut off after the break and sync have been accepted. The block must then ignore the rest of the header even though valid bits keep arriving. The bench pulses the enable low in the middle of the identifier byte, and in a second test changes the command in the middle of the sync byte. In both cases it lets the remaining bits run on and then checks the identifier, the measured period and the timeout pulse count. A second hard case is the tolerance edge of the sync measurement. This is reached by sending whole headers at bit periods of 13, 14, 18 and 19 clocks around the 16-clock nominal, together with break lengths of 175 and 176 clocks.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SYNC_WAIT,
      ST_SYNC,
      ST_PID_WAIT,
      ST_PID
   } hdr_st_e;

   // Both identifier parity bits must agree with the identifier bits.
   function automatic logic pid_par_ok(input logic [7:0] b);
      return (b[6] == (b[0] ^ b[1] ^ b[2] ^ b[4])) &&
             (b[7] == ~(b[1] ^ b[3] ^ b[4] ^ b[5]));
   endfunction

   // Response length in bytes from identifier bits 5:4 (legacy mode).
   function automatic logic [3:0] lin13_len(input logic [1:0] sel);
      case (sel)
         2'b10:   return 4'd4;
         2'b11:   return 4'd8;
         default: return 4'd2;
      endcase
   endfunction

endpackage

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
   parameter int BRK_LEN = 176
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic rx_i,
   output logic brk_o
);
   localparam int BW = $clog2(BRK_LEN + 1);

   logic [BW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         brk_o   <= 1'b0;
      end else if (clr_i) begin
         low_cnt <= '0;
         brk_o   <= 1'b0;
      end else begin
         // Recognise the break on the first high sample after a long low.
         brk_o <= rx_i && (low_cnt >= BW'(BRK_LEN));
         if (!rx_i) begin
            if (low_cnt != BW'(BRK_LEN)) low_cnt <= low_cnt + 1'b1;
         end else begin
            low_cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/lin_sync_meas.sv
module lin_sync_meas #(
   parameter int NOM_BIT = 16,
   parameter int TOL_PCT = 14,
   parameter int CW      = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          fall_i,
   output logic          done_o,
   output logic          err_o,
   output logic [CW-1:0] per_o
);
   localparam int NOM8 = 8 * NOM_BIT;
   localparam int LO   = NOM8 * (100 - TOL_PCT) / 100;
   localparam int HI   = NOM8 * (100 + TOL_PCT) / 100;

   logic [CW-1:0] span;
   logic [1:0]    edges;
   logic [CW-1:0] total;
   logic          last, in_rng;

   assign total  = span + 1'b1;
   assign last   = run_i && fall_i && (edges == 2'd3);
   assign in_rng = (total >= CW'(LO)) && (total <= CW'(HI));
   assign done_o = last && in_rng;
   assign err_o  = run_i && ((last && !in_rng) || (!last && total > CW'(HI)));
   assign per_o  = total >> 3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         span  <= '0;
         edges <= '0;
      end else if (!run_i) begin
         span  <= '0;
         edges <= '0;
      end else begin
         span <= span + 1'b1;
         if (fall_i) edges <= edges + 1'b1;
      end
   end
endmodule

// File: rtl/lin_byte_rx.sv
module lin_byte_rx #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          rx_i,
   input  logic [CW-1:0] per_i,
   output logic          done_o,
   output logic [7:0]    data_o
);
   logic [CW-1:0] tick;
   logic [3:0]    idx;
   logic [7:0]    sh;
   logic          smp;

   assign smp    = run_i && (tick == (per_i >> 1));
   assign done_o = smp && (idx == 4'd8);
   assign data_o = {rx_i, sh[7:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick <= '0;
         idx  <= '0;
         sh   <= '0;
      end else if (!run_i) begin
         tick <= '0;
         idx  <= '0;
      end else begin
         tick <= (tick == per_i - 1'b1) ? '0 : tick + 1'b1;
         if (smp) begin
            idx <= idx + 1'b1;
            if (idx != 4'd0) sh <= {rx_i, sh[7:1]};
         end
      end
   end
endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
   import lin_hdr_pkg::*;
#(
   parameter int NOM_BIT  = 16,
   parameter int BRK_BITS = 11,
   parameter int TOL_PCT  = 14,
   parameter bit LIN13_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en_i,
   input  logic [2:0]                    cmd_i,
   input  logic                          lin13_i,
   input  logic                          rx_i,
   output logic [7:0]                    pid_o,
   output logic [3:0]                    dlen_o,
   output logic [$clog2(16*NOM_BIT)-1:0] bit_per_o,
   output logic                          hdr_ok_o,
   output logic                          par_err_o,
   output logic                          sync_err_o,
   output logic                          tmo_start_o
);
   localparam int CW      = $clog2(16 * NOM_BIT);
   localparam int BRK_LEN = BRK_BITS * NOM_BIT;

   if (NOM_BIT < 4) begin : g_bad_nom
      $error("NOM_BIT must be at least 4");
   end
   if (BRK_BITS < 10) begin : g_bad_brk
      $error("BRK_BITS must exceed a character length");
   end
   if (TOL_PCT < 1 || TOL_PCT > 49) begin : g_bad_tol
      $error("TOL_PCT must lie in 1..49");
   end

   hdr_st_e       st;
   logic          active, rx_d, fall, brk;
   logic          s_done, s_err, b_done, pid_good;
   logic [CW-1:0] s_per;
   logic [7:0]    b_data;

   assign active = en_i && (cmd_i == 3'b000);
   assign fall   = rx_d && !rx_i;

   lin_brk_det #(.BRK_LEN(BRK_LEN)) u_brk (
      .clk(clk), .rst_n(rst_n), .clr_i(!active), .rx_i(rx_i), .brk_o(brk)
   );

   lin_sync_meas #(.NOM_BIT(NOM_BIT), .TOL_PCT(TOL_PCT), .CW(CW)) u_sync (
      .clk(clk), .rst_n(rst_n), .run_i(active && st == ST_SYNC), .fall_i(fall),
      .done_o(s_done), .err_o(s_err), .per_o(s_per)
   );

   lin_byte_rx #(.CW(CW)) u_byte (
      .clk(clk), .rst_n(rst_n), .run_i(active && st == ST_PID), .rx_i(rx_i),
      .per_i(bit_per_o), .done_o(b_done), .data_o(b_data)
   );

   assign pid_good = active && !brk && (st == ST_PID) && b_done && pid_par_ok(b_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         rx_d        <= 1'b1;
         pid_o       <= '0;
         bit_per_o   <= CW'(NOM_BIT);
         hdr_ok_o    <= 1'b0;
         par_err_o   <= 1'b0;
         sync_err_o  <= 1'b0;
         tmo_start_o <= 1'b0;
      end else begin
         rx_d        <= rx_i;
         tmo_start_o <= 1'b0;
         if (!active) begin
            st <= ST_IDLE;
         end else if (brk) begin
            st         <= ST_SYNC_WAIT;
            hdr_ok_o   <= 1'b0;
            par_err_o  <= 1'b0;
            sync_err_o <= 1'b0;
         end else begin
            case (st)
               ST_SYNC_WAIT: if (fall) st <= ST_SYNC;
               ST_SYNC: begin
                  if (s_err) begin
                     sync_err_o <= 1'b1;
                     st         <= ST_IDLE;
                  end else if (s_done) begin
                     bit_per_o <= s_per;
                     st        <= ST_PID_WAIT;
                  end
               end
               ST_PID_WAIT: if (fall) st <= ST_PID;
               ST_PID: begin
                  if (b_done) begin
                     pid_o <= b_data;
                     st    <= ST_IDLE;
                     if (pid_good) begin
                        hdr_ok_o    <= 1'b1;
                        tmo_start_o <= 1'b1;
                     end else begin
                        par_err_o <= 1'b1;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   if (LIN13_EN) begin : g_len13
      logic [3:0] dlen_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   dlen_q <= '0;
         else if (pid_good && lin13_i) dlen_q <= lin13_len(b_data[5:4]);
      end
      assign dlen_o = dlen_q;
   end else begin : g_len_off
      logic unused_lin13;
      assign unused_lin13 = lin13_i;
      assign dlen_o       = '0;
   end
endmodule

// File: rtl/lin_hdr_rx_chk.sv
module lin_hdr_rx_chk
   import lin_hdr_pkg::*;
#(
   parameter int NOM_BIT = 16,
   parameter int TOL_PCT = 14
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          en_i,
   input logic [2:0]                    cmd_i,
   input logic                          lin13_i,
   input logic [7:0]                    pid_o,
   input logic [3:0]                    dlen_o,
   input logic [$clog2(16*NOM_BIT)-1:0] bit_per_o,
   input logic                          hdr_ok_o,
   input logic                          par_err_o,
   input logic                          sync_err_o,
   input logic                          tmo_start_o
);
   localparam int CW   = $clog2(16 * NOM_BIT);
   localparam int PMIN = (8 * NOM_BIT * (100 - TOL_PCT) / 100) / 8;
   localparam int PMAX = (8 * NOM_BIT * (100 + TOL_PCT) / 100) / 8;

   assert_tmo_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_start_o |=> !tmo_start_o);
   assert_tmo_with_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_start_o |-> (hdr_ok_o && !par_err_o));
   assert_par_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_ok_o && par_err_o));
   assert_ok_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hdr_ok_o) |-> pid_par_ok(pid_o));
   assert_sync_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_ok_o && sync_err_o));
   assert_per_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_per_o >= CW'(PMIN)) && (bit_per_o <= CW'(PMAX)));
   assert_dlen_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dlen_o == 4'd0) || (dlen_o == 4'd2) || (dlen_o == 4'd4) || (dlen_o == 4'd8));
   assert_dlen_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dlen_o) |-> $past(lin13_i));
   assert_pid_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pid_o) |-> ($past(en_i) && $past(cmd_i) == 3'b000));
   assert_tmo_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_start_o |-> ($past(en_i) && $past(cmd_i) == 3'b000));
endmodule

bind lin_hdr_rx lin_hdr_rx_chk #(.NOM_BIT(NOM_BIT), .TOL_PCT(TOL_PCT)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .cmd_i(cmd_i), .lin13_i(lin13_i),
   .pid_o(pid_o), .dlen_o(dlen_o), .bit_per_o(bit_per_o), .hdr_ok_o(hdr_ok_o),
   .par_err_o(par_err_o), .sync_err_o(sync_err_o), .tmo_start_o(tmo_start_o)
);

// File: tb/lin_hdr_rx_tb.sv
module lin_hdr_rx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b1;
   logic [2:0] cmd_i = 3'b000;
   logic       lin13_i = 1'b1;
   logic       rx_i = 1'b1;
   logic [7:0] pid_o;
   logic [3:0] dlen_o;
   logic [7:0] bit_per_o;
   logic       hdr_ok_o, par_err_o, sync_err_o, tmo_start_o;

   int errors = 0;
   int checks = 0;
   int tmo_cnt = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   lin_hdr_rx u_dut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .cmd_i(cmd_i), .lin13_i(lin13_i),
      .rx_i(rx_i), .pid_o(pid_o), .dlen_o(dlen_o), .bit_per_o(bit_per_o),
      .hdr_ok_o(hdr_ok_o), .par_err_o(par_err_o), .sync_err_o(sync_err_o),
      .tmo_start_o(tmo_start_o)
   );

   always @(negedge clk) if (tmo_start_o) tmo_cnt++;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mk_pid(input logic [5:0] id, input logic flip);
      logic p0, p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1 ^ flip, p0, id};
   endfunction

   task automatic hold(input logic v, input int n);
      rx_i = v;
      repeat (n) @(negedge clk);
   endtask

   // cut >= 0: pulse the control before that bit (kind 0 = enable, 1 = command)
   task automatic send_byte(input logic [7:0] b, input int p, input int cut, input int kind);
      hold(1'b0, p);
      for (int i = 0; i < 8; i++) begin
         if (i == cut) begin
            if (kind == 0) en_i = 1'b0; else cmd_i = 3'b010;
            repeat (2) @(negedge clk);
            en_i  = 1'b1;
            cmd_i = 3'b000;
         end
         hold(b[i], p);
      end
      hold(1'b1, p);
   endtask

   task automatic send_frame(input logic [7:0] pid, input int p, input int blen,
                             input int sync_cut, input int pid_cut);
      tmo_cnt = 0;
      hold(1'b1, 4);
      hold(1'b0, blen);
      hold(1'b1, p);
      send_byte(8'h55, p, sync_cut, 1);
      send_byte(pid, p, pid_cut, 0);
      hold(1'b1, 2 * p);
   endtask

   typedef struct packed {
      logic [5:0] id;
      logic [4:0] per;
      logic       l13;
      logic       flip;
      logic       ok;
      logic       perr;
      logic       serr;
      logic [3:0] dlen;
      logic [4:0] eper;
   } vec_t;

   localparam vec_t VEC [9] = '{
      '{6'h00, 5'd16, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 5'd16},
      '{6'h1A, 5'd16, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 5'd16},
      '{6'h25, 5'd18, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 5'd18},
      '{6'h3C, 5'd14, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 5'd14},
      '{6'h2A, 5'd16, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 5'd16},
      '{6'h11, 5'd16, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8, 5'd16},
      '{6'h05, 5'd19, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, 5'd16},
      '{6'h07, 5'd13, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, 5'd16},
      '{6'h21, 5'd17, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 5'd17}
   };

   initial begin
      logic [7:0] exp_pid;
      logic [7:0] b;
      exp_pid = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 hdr_ok", hdr_ok_o, 0);
      chk("R1 par_err", par_err_o, 0);
      chk("R1 sync_err", sync_err_o, 0);
      chk("R1 tmo_start", tmo_start_o, 0);
      chk("R1 pid", pid_o, 0);
      chk("R1 dlen", dlen_o, 0);
      chk("R1 bit_per", bit_per_o, 16);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Vector walk: R3 R4 R5 R6 R7 R8 R9
      for (int k = 0; k < 9; k++) begin
         lin13_i = VEC[k].l13;
         b = mk_pid(VEC[k].id, VEC[k].flip);
         send_frame(b, int'(VEC[k].per), 200, -1, -1);
         if (!VEC[k].serr) exp_pid = b;
         chk("R8 hdr_ok", hdr_ok_o, int'(VEC[k].ok));
         chk("R6 par_err (R9 cleared)", par_err_o, int'(VEC[k].perr));
         chk("R4 sync_err (R9 cleared)", sync_err_o, int'(VEC[k].serr));
         chk("R5 pid", pid_o, exp_pid);
         chk("R7 dlen", dlen_o, int'(VEC[k].dlen));
         chk("R3 bit_per", bit_per_o, int'(VEC[k].eper));
         chk("R8 tmo pulses", tmo_cnt, int'(VEC[k].ok));
      end
      lin13_i = 1'b1;

      // R2: one clock short of the break length
      send_frame(mk_pid(6'h0F, 1'b0), 16, 175, -1, -1);
      chk("R2 short break pid", pid_o, exp_pid);
      chk("R2 short break hdr_ok", hdr_ok_o, 1);
      chk("R2 short break bit_per", bit_per_o, 17);
      chk("R2 short break tmo", tmo_cnt, 0);

      // R2: exactly the break length
      b = mk_pid(6'h0F, 1'b0);
      send_frame(b, 16, 176, -1, -1);
      exp_pid = b;
      chk("R2 exact break pid", pid_o, exp_pid);
      chk("R2 exact break hdr_ok", hdr_ok_o, 1);
      chk("R2 exact break bit_per", bit_per_o, 16);
      chk("R2 exact break tmo", tmo_cnt, 1);
      chk("R7 exact break dlen", dlen_o, 2);

      // R10: enable dropped inside the identifier byte
      send_frame(mk_pid(6'h33, 1'b0), 16, 200, -1, 3);
      chk("R10 en abort pid", pid_o, exp_pid);
      chk("R10 en abort hdr_ok", hdr_ok_o, 0);
      chk("R10 en abort tmo", tmo_cnt, 0);
      chk("R10 en abort dlen", dlen_o, 2);

      // R10: command changed inside the sync byte
      send_frame(mk_pid(6'h12, 1'b0), 15, 200, 4, -1);
      chk("R10 cmd abort bit_per", bit_per_o, 16);
      chk("R10 cmd abort sync_err", sync_err_o, 0);
      chk("R10 cmd abort pid", pid_o, exp_pid);
      chk("R10 cmd abort tmo", tmo_cnt, 0);

      // R10: recovery with a clean header afterwards
      b = mk_pid(6'h12, 1'b0);
      send_frame(b, 15, 200, -1, -1);
      chk("R10 recover pid", pid_o, b);
      chk("R3 recover bit_per", bit_per_o, 15);
      chk("R8 recover hdr_ok", hdr_ok_o, 1);
      chk("R7 recover dlen", dlen_o, 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule